// File: doc/BRIEF.md
# L1 Data-Cache Tag Store with Selective Type Flush

This block holds the tags, valid bits and a per-line memory-type bit for a 16 KB, two-way set-associative L1 data cache with 32-byte lines. A line filled from a page that carries the special message-buffer type has its type bit set. Such data may sit in L1 but is never kept at the next cache level. Software uses a single strobe to drop every line that carries that type in one clock. Untyped lines keep their state, and nothing is written back. Any later access to a dropped line misses and goes to memory.

The lookup port is combinational against the stored state. It returns a hit flag and the way that hit. The fill port writes a tag and the type bit into a way that the block chooses itself. It reports that choice on `fill_way` in the same cycle. A one-bit least-recently-used marker per set picks the victim when both ways of the set are occupied.

The block has no state machine. Its only sequential elements are the tag, valid, type and LRU arrays. They are updated on the rising edge from the fill, invalidate and lookup-hit controls.

Top module: `l1tag_store`

## Requirements
- R1: Addresses are 32 bits. Bits [4:0] are the line offset and are ignored. Bits [12:5] select one of 256 sets, and bits [31:13] form the 19-bit tag. Each set has two ways.
- R2: After reset every line is invalid, so every lookup misses.
- R3: When `lk_en` is high and a valid line in the indexed set holds the address tag, `lk_hit` is 1 in the same cycle and `lk_way` gives that way (0 or 1). `lk_hit` is 0 whenever `lk_en` is low.
- R4: A fill writes the tag, sets the valid bit and records `fill_typed` in the chosen way. A lookup sees the new line from the next cycle on, and a lookup in the fill's own cycle sees the old contents.
- R5: When `inv_typed` is high at a rising edge, every line whose type bit is 1 becomes invalid at that edge. No data is written back, and later lookups of those lines miss.
- R6: Lines whose type bit is 0 keep their valid state and tag across a typed invalidate.
- R7: A lookup in the same cycle as `inv_typed` sees the state before the invalidate.
- R8: The fill way is chosen in this order: the way already holding the tag (so a tag never sits in both ways of a set), then the lowest-numbered invalid way, then the way named by the set's LRU bit. `fill_way` shows the choice combinationally, and the choice uses the state before any invalidate in the same cycle.
- R9: A lookup hit makes the other way of its set the LRU victim. A fill makes the way it did not write the victim. When a fill and a lookup hit touch the same set in one cycle, the fill's update wins.
- R10: A fill in the same cycle as `inv_typed` leaves the filled line valid with its new type bit, even if that bit is 1. The invalidate acts on all other lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_en | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup byte address |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_way | output | 1 | Way that hit |
| fill_en | input | 1 | Write a line at the rising edge |
| fill_addr | input | 32 | Byte address of the line being filled |
| fill_typed | input | 1 | Type bit stored with the filled line |
| fill_way | output | 1 | Way the fill uses (combinational) |
| inv_typed | input | 1 | Invalidate every typed line at the rising edge |

## Verification
The typed invalidate can coincide with both a fill and a lookup in the same cycle. The bench drives `inv_typed` together with a typed fill and with a lookup of a typed line. It judges the lookup against the state before the edge. It then looks up every involved line in the following cycles and expects the new typed line to hit, old typed lines to miss, and untyped lines to hit unchanged. A fill and a lookup hit are also aimed at one set in one cycle, and the next victim choice shows which LRU update won. A randomised phase mixes all three controls over a few sets against a reference model.

// File: rtl/l1tag_pkg.sv
package l1tag_pkg;
    localparam int ADDR_W      = 32;
    localparam int CACHE_BYTES = 16384;
    localparam int LINE_BYTES  = 32;
    localparam int NUM_WAYS    = 2;
    localparam int SETS        = CACHE_BYTES / (LINE_BYTES * NUM_WAYS);
    localparam int OFF_W       = $clog2(LINE_BYTES);
    localparam int IDX_W       = $clog2(SETS);
    localparam int TAG_W       = ADDR_W - IDX_W - OFF_W;
    localparam int WAY_W       = $clog2(NUM_WAYS);

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [WAY_W-1:0] way_t;

    function automatic idx_t addr_idx(input logic [ADDR_W-1:0] a);
        return a[OFF_W +: IDX_W];
    endfunction

    function automatic tag_t addr_tag(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction
endpackage

// File: rtl/l1tag_way.sv
module l1tag_way
    import l1tag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  idx_t lk_idx,
    input  tag_t lk_tag,
    output logic lk_match,
    output logic lk_typed,
    input  idx_t fl_idx,
    input  tag_t fl_tag,
    output logic fl_match,
    output logic fl_valid,
    input  logic wr_en,
    input  logic wr_typed,
    input  logic inv_typed
);
    logic [SETS-1:0] vld_q;
    logic [SETS-1:0] typ_q;
    tag_t            tag_q [SETS];

    // Valid and type bits: flash clear of typed lines, fill overrides its own line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            typ_q <= '0;
        end else begin
            if (inv_typed) begin
                vld_q <= vld_q & ~typ_q;
            end
            if (wr_en) begin
                vld_q[fl_idx] <= 1'b1;
                typ_q[fl_idx] <= wr_typed;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[fl_idx] <= fl_tag;
        end
    end

    always_comb begin
        lk_match = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_typed = typ_q[lk_idx];
        fl_match = vld_q[fl_idx] && (tag_q[fl_idx] == fl_tag);
        fl_valid = vld_q[fl_idx];
    end

    AST_TYPED_ALL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        inv_typed && !wr_en |=> (vld_q & typ_q) == '0);                          // R5
    AST_UNTYPED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        inv_typed && !wr_en |=> (vld_q & ~typ_q) == $past(vld_q & ~typ_q));     // R6
    AST_FILL_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(fl_idx)] && (typ_q[$past(fl_idx)] == $past(wr_typed))); // R10
endmodule

// File: rtl/l1tag_lru.sv
module l1tag_lru
    import l1tag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic touch_en,
    input  idx_t touch_idx,
    input  way_t touch_way,
    input  logic fill_en,
    input  idx_t fill_idx,
    input  way_t fill_way,
    output way_t victim
);
    way_t lru_q [SETS];

    // Later assignment wins: a fill overrides a lookup touch on the same set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                lru_q[s] <= '0;
            end
        end else begin
            if (touch_en) begin
                lru_q[touch_idx] <= ~touch_way;
            end
            if (fill_en) begin
                lru_q[fill_idx] <= ~fill_way;
            end
        end
    end

    assign victim = lru_q[fill_idx];

    AST_FILL_SETS_LRU: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> lru_q[$past(fill_idx)] != $past(fill_way));                // R9
endmodule

// File: rtl/l1tag_store.sv
module l1tag_store
    import l1tag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_en,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [WAY_W-1:0]  lk_way,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_typed,
    output logic [WAY_W-1:0]  fill_way,
    input  logic              inv_typed
);
    idx_t                lk_idx, fl_idx;
    tag_t                lk_tag, fl_tag;
    logic [NUM_WAYS-1:0] hit_vec, typ_vec, fm_vec, fv_vec;
    way_t                lru_victim;

    assign lk_idx = addr_idx(lk_addr);
    assign lk_tag = addr_tag(lk_addr);
    assign fl_idx = addr_idx(fill_addr);
    assign fl_tag = addr_tag(fill_addr);

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        l1tag_way u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .lk_idx    (lk_idx),
            .lk_tag    (lk_tag),
            .lk_match  (hit_vec[w]),
            .lk_typed  (typ_vec[w]),
            .fl_idx    (fl_idx),
            .fl_tag    (fl_tag),
            .fl_match  (fm_vec[w]),
            .fl_valid  (fv_vec[w]),
            .wr_en     (fill_en && (fill_way == WAY_W'(w))),
            .wr_typed  (fill_typed),
            .inv_typed (inv_typed)
        );
    end

    always_comb begin
        lk_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (hit_vec[w]) lk_way = WAY_W'(w);
        end
        lk_hit = lk_en && (|hit_vec);
    end

    // Fill way: matching way, then lowest invalid way, then LRU victim
    always_comb begin
        logic found;
        found    = 1'b0;
        fill_way = lru_victim;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (!found && fm_vec[w]) begin
                fill_way = WAY_W'(w);
                found    = 1'b1;
            end
        end
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (!found && !fv_vec[w]) begin
                fill_way = WAY_W'(w);
                found    = 1'b1;
            end
        end
    end

    l1tag_lru u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (lk_hit),
        .touch_idx (lk_idx),
        .touch_way (lk_way),
        .fill_en   (fill_en),
        .fill_idx  (fl_idx),
        .fill_way  (fill_way),
        .victim    (lru_victim)
    );

    AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));                                                      // R8
    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !(|hit_vec));                                           // R2
    AST_TYPED_MISS_AFTER_INV: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en && $past(inv_typed) && !$past(fill_en) |-> !(|(hit_vec & typ_vec))); // R5
    AST_NO_HIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_en |-> !lk_hit);                                                     // R3
endmodule

// File: tb/l1tag_store_tb.sv
module l1tag_store_tb_top;
    import l1tag_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_en = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              lk_hit;
    logic [WAY_W-1:0]  lk_way;
    logic              fill_en = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic              fill_typed = 1'b0;
    logic [WAY_W-1:0]  fill_way;
    logic              inv_typed = 1'b0;

    always #5 clk = ~clk;

    l1tag_store dut_i (
        .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_way(lk_way), .fill_en(fill_en),
        .fill_addr(fill_addr), .fill_typed(fill_typed),
        .fill_way(fill_way), .inv_typed(inv_typed)
    );

    typedef struct {
        string req;
        bit    is_fill;
        bit    exp_hit;
        bit    exp_way;
    } sb_item_t;

    sb_item_t sbq[$];
    int       n_chk = 0;
    int       n_err = 0;
    bit       done = 1'b0;

    bit   m_vld [NUM_WAYS][SETS];
    bit   m_typ [NUM_WAYS][SETS];
    tag_t m_tag [NUM_WAYS][SETS];
    bit   m_lru [SETS];

    function automatic logic [31:0] mk(input int tag, input int set, input int off);
        return {19'(tag), 8'(set), 5'(off)};
    endfunction

    // Driver: drive one cycle, push expectations, advance reference model
    task automatic step(input bit le, input logic [31:0] la, input bit fe,
                        input logic [31:0] fa, input bit ft, input bit iv,
                        input string rq);
        idx_t li, fi;
        tag_t lt, ft_tag;
        bit eh, ew, fw, found;
        sb_item_t it;
        @(negedge clk);
        lk_en = le; lk_addr = la; fill_en = fe; fill_addr = fa;
        fill_typed = ft; inv_typed = iv;
        li = la[12:5]; lt = la[31:13]; fi = fa[12:5]; ft_tag = fa[31:13];
        eh = 1'b0; ew = 1'b0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (le && m_vld[w][li] && m_tag[w][li] == lt) begin eh = 1'b1; ew = w[0]; end
        end
        it.req = rq; it.is_fill = 1'b0; it.exp_hit = eh; it.exp_way = ew;
        sbq.push_back(it);
        found = 1'b0; fw = m_lru[fi];
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (!found && m_vld[w][fi] && m_tag[w][fi] == ft_tag) begin fw = w[0]; found = 1'b1; end
        end
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (!found && !m_vld[w][fi]) begin fw = w[0]; found = 1'b1; end
        end
        if (fe) begin
            it.req = rq; it.is_fill = 1'b1; it.exp_hit = 1'b0; it.exp_way = fw;
            sbq.push_back(it);
        end
        if (iv) begin
            for (int w = 0; w < NUM_WAYS; w++)
                for (int s = 0; s < SETS; s++)
                    if (m_typ[w][s]) m_vld[w][s] = 1'b0;
        end
        if (eh) m_lru[li] = ~ew;
        if (fe) begin
            m_vld[fw][fi] = 1'b1; m_typ[fw][fi] = ft; m_tag[fw][fi] = ft_tag;
            m_lru[fi] = ~fw;
        end
    endtask

    task automatic look(input logic [31:0] a, input string rq);
        step(1'b1, a, 1'b0, '0, 1'b0, 1'b0, rq);
    endtask

    task automatic fill(input logic [31:0] a, input bit t, input string rq);
        step(1'b0, '0, 1'b1, a, t, 1'b0, rq);
    endtask

    // Monitor: pop and compare while outputs are settled, away from the edge
    always begin
        @(negedge clk);
        #3;
        while (sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            n_chk++;
            if (it.is_fill) begin
                if (fill_way !== it.exp_way) begin
                    n_err++;
                    $display("FAIL %s fill_way actual=%0d expected=%0d", it.req, fill_way, it.exp_way);
                end
            end else if (lk_hit !== it.exp_hit || (it.exp_hit && lk_way !== it.exp_way)) begin
                n_err++;
                $display("FAIL %s lookup actual hit=%0d way=%0d expected hit=%0d way=%0d",
                         it.req, lk_hit, lk_way, it.exp_hit, it.exp_way);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < NUM_WAYS; w++)
            for (int s = 0; s < SETS; s++) begin
                m_vld[w][s] = 1'b0; m_typ[w][s] = 1'b0; m_tag[w][s] = '0;
            end
        for (int s = 0; s < SETS; s++) m_lru[s] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        look(mk(0, 0, 0), "R2");
        look(mk(5, 200, 4), "R2");
        // Fill A in set 5; lookup in the fill cycle sees old content
        step(1'b1, mk(1, 5, 0), 1'b1, mk(1, 5, 0), 1'b0, 1'b0, "R4_R8");
        look(mk(1, 5, 0), "R4");
        look(mk(1, 5, 31), "R1");
        step(1'b0, mk(1, 5, 0), 1'b0, '0, 1'b0, 1'b0, "R3");
        fill(mk(2, 5, 0), 1'b1, "R8");
        look(mk(2, 5, 8), "R3");
        look(mk(1, 5, 0), "R9");
        fill(mk(3, 5, 0), 1'b0, "R9");
        look(mk(2, 5, 0), "R9");
        look(mk(3, 5, 0), "R9");
        fill(mk(1, 5, 0), 1'b1, "R8");
        look(mk(1, 5, 0), "R8");
        fill(mk(4, 7, 0), 1'b1, "R4");
        fill(mk(5, 7, 0), 1'b0, "R4");
        // Invalidate with a lookup of a typed line in the same cycle
        step(1'b1, mk(1, 5, 0), 1'b0, '0, 1'b0, 1'b1, "R7");
        look(mk(1, 5, 0), "R5");
        look(mk(3, 5, 0), "R6");
        look(mk(4, 7, 0), "R5");
        look(mk(5, 7, 0), "R6");
        // Typed fill together with invalidate
        fill(mk(6, 9, 0), 1'b1, "R10");
        step(1'b0, '0, 1'b1, mk(7, 9, 0), 1'b1, 1'b1, "R10");
        look(mk(7, 9, 0), "R10");
        look(mk(6, 9, 0), "R5");
        // Fill and lookup hit on the same set in one cycle
        step(1'b1, mk(3, 5, 0), 1'b1, mk(8, 5, 0), 1'b0, 1'b0, "R9");
        fill(mk(9, 5, 0), 1'b0, "R9");
        look(mk(9, 5, 0), "R9");
        look(mk(8, 5, 0), "R9");

        for (int i = 0; i < 400; i++) begin
            step($urandom_range(0, 3) != 0, mk($urandom_range(1, 4), $urandom_range(20, 22), $urandom_range(0, 31)),
                 $urandom_range(0, 2) == 0, mk($urandom_range(1, 4), $urandom_range(20, 22), 0),
                 $urandom_range(0, 1) == 1, $urandom_range(0, 7) == 0, "R5_R6_R8_R9_R10_random");
        end
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R3");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule